// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns one character into an asynchronous frame on a single serial line that rests high. A character and its frame settings are written into a one-entry holding register with a load strobe. When the next bit-rate enable pulse arrives, the holding register empties into a shift register and the frame goes out one bit per bit-rate period. Each frame has a low start bit, then 7 or 8 data bits in either order, then an optional extra bit, then one or two high stop bits.

There are two modes. In normal mode the extra bit is a parity bit, even or odd, and it can be switched off. In multiprocessor mode the extra bit is always sent and carries an address/data flag given with the character. Because the holding register is separate from the shift register, software can queue the next character while the current frame is still going out. The frames then follow each other with no idle gap.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is queued or being sent, `tx_line` is 1, `busy` is 0 and `buf_empty` is 1.
- R2: A `load` pulse while `buf_empty` is 1 captures `load_data` and all `cfg_*` inputs, and `buf_empty` reads 0 in the next cycle. A `load` while `buf_empty` is 0 is ignored: the character already held is the one that gets sent.
- R3: On the first `bit_tick` that finds a held character and no frame in progress, the start bit (0) appears on `tx_line` in the next cycle. `buf_empty` returns to 1 in that same cycle.
- R4: Each bit stays on `tx_line` from one `bit_tick` to the next. The line changes only in the cycle after a `bit_tick`.
- R5: With `cfg_len8`=1 the data field is `load_data[7:0]`. With `cfg_len8`=0 it is `load_data[6:0]` and bit 7 is never sent.
- R6: With `cfg_msb_first`=0 the data goes out lowest bit first. With `cfg_msb_first`=1 it goes out highest used bit first (D7..D0, or D6..D0 for 7 bits).
- R7: In normal mode (`cfg_mp_mode`=0) with `cfg_par_en`=1, a parity bit follows the last data bit. It makes the count of ones over the sent data bits plus parity even when `cfg_par_odd`=0, and odd when it is 1. With `cfg_par_en`=0 there is no parity bit.
- R8: In multiprocessor mode (`cfg_mp_mode`=1) the bit after the last data bit is `cfg_mp_addr`, whatever `cfg_par_en` is set to.
- R9: One stop bit (`cfg_two_stop`=0) or two stop bits (`cfg_two_stop`=1), each 1, close the frame. The frame lasts 1 + data bits + extra bit (0 or 1) + stop bits periods.
- R10: `busy` is 1 from the cycle after a load is accepted until the `bit_tick` that ends the last stop bit. When it falls, `tx_line` is 1.
- R11: If a character is held when the last stop bit ends, its start bit follows at once, on that same `bit_tick`, with no idle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle bit-rate enable pulse |
| load | input | 1 | Strobe that writes a character into the holding register |
| load_data | input | 8 | Character to send |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity on (normal mode only) |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| cfg_msb_first | input | 1 | 1: highest data bit first |
| cfg_mp_mode | input | 1 | 1: multiprocessor mode |
| cfg_mp_addr | input | 1 | Address/data flag sent in multiprocessor mode |
| tx_line | output | 1 | Serial output, idle high |
| busy | output | 1 | Character held or frame in progress |
| buf_empty | output | 1 | Holding register can accept a character |

## Verification
The bench captures every frame bit by bit and compares it with a frame built from the requirements. It covers both bit orders with 7-bit characters, where a design that reversed all 8 bits would leak bit 7 and drop bit 0. In multiprocessor mode it also sets parity on, which would expose a design that sent parity instead of the flag. A load written while the holding register is full must not replace the held character, or the wrong byte goes out. Two queued characters must run back to back: an idle bit or a lost start bit between them shows up as a shifted stream. The bench also checks that `busy` falls exactly on the tick after the last stop bit, which catches a frame that is one bit too long or too short.

// File: rtl/aftx_pkg.sv
package aftx_pkg;

    // Per-character frame settings, captured together with the data byte
    typedef struct packed {
        logic len8;       // 1: full-width character, 0: one bit shorter
        logic par_en;     // parity bit present in normal mode
        logic par_odd;    // odd parity when 1
        logic two_stop;   // two stop bits when 1
        logic msb_first;  // highest data bit leaves first
        logic mp_mode;    // multiprocessor mode: flag replaces parity
        logic mp_addr;    // flag value in multiprocessor mode
    } aftx_cfg_t;

    localparam int unsigned AFTX_EXTRA_MAX = 1;  // parity or address flag
    localparam int unsigned AFTX_STOP_MAX  = 2;

endpackage

// File: rtl/aftx_holding.sv
module aftx_holding
    import aftx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  aftx_cfg_t         load_cfg,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] held_data,
    output aftx_cfg_t         held_cfg
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
        aftx_cfg_t         cfg;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) begin
            hold_d.full = 1'b0;
        end
        // a write is only taken into an empty register; one that arrives
        // while a character is held is dropped, even in the cycle it leaves
        if (load && !hold_q.full) begin
            hold_d.full = 1'b1;
            hold_d.data = load_data;
            hold_d.cfg  = load_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign full      = hold_q.full;
    assign held_data = hold_q.data;
    assign held_cfg  = hold_q.cfg;

endmodule

// File: rtl/aftx_framer.sv
module aftx_framer
    import aftx_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned FRAME_W = 1 + DATA_W + AFTX_EXTRA_MAX + AFTX_STOP_MAX,
    parameter int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  aftx_cfg_t          cfg,
    output logic [FRAME_W-1:0] frame,   // bit 0 leaves first
    output logic [CNT_W-1:0]   frame_len
);

    logic [DATA_W-1:0] src;      // character aligned so its top used bit sits at DATA_W-1
    logic              par_acc;
    logic              extra_en;
    logic              extra_bit;
    logic              cur;

    always_comb begin
        src      = cfg.len8 ? data : {data[DATA_W-2:0], 1'b0};
        frame    = '1;            // stop bits and padding are mark level
        frame[0] = 1'b0;          // start bit
        par_acc  = cfg.par_odd;
        cur      = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < DATA_W - 1 || cfg.len8) begin
                cur          = cfg.msb_first ? src[DATA_W-1-i] : data[i];
                frame[1 + i] = cur;
                par_acc      = par_acc ^ cur;
            end
        end
        extra_en  = cfg.mp_mode | cfg.par_en;
        extra_bit = cfg.mp_mode ? cfg.mp_addr : par_acc;
        if (extra_en) begin
            if (cfg.len8) begin
                frame[1 + DATA_W] = extra_bit;
            end else begin
                frame[DATA_W] = extra_bit;
            end
        end
        frame_len = CNT_W'(1)
                  + (cfg.len8 ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1))
                  + (extra_en ? CNT_W'(1) : CNT_W'(0))
                  + (cfg.two_stop ? CNT_W'(2) : CNT_W'(1));
    end

endmodule

// File: rtl/aftx_shifter.sv
module aftx_shifter #(
    parameter int unsigned FRAME_W = 12,
    parameter int unsigned CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic               have_next,
    input  logic [FRAME_W-1:0] next_frame,
    input  logic [CNT_W-1:0]   next_len,
    output logic               take,
    output logic               active,
    output logic               line
);

    typedef struct packed {
        logic               active;
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   left;   // bits still owed, current one included
        logic               line;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        take  = 1'b0;
        if (bit_tick) begin
            if (shf_q.active && shf_q.left > CNT_W'(1)) begin
                shf_d.shreg = {1'b1, shf_q.shreg[FRAME_W-1:1]};
                shf_d.left  = shf_q.left - CNT_W'(1);
                shf_d.line  = shf_q.shreg[1];
            end else if (have_next) begin
                // idle, or last stop bit just ended: next frame starts now
                take         = 1'b1;
                shf_d.active = 1'b1;
                shf_d.shreg  = next_frame;
                shf_d.left   = next_len;
                shf_d.line   = next_frame[0];
            end else begin
                shf_d.active = 1'b0;
                shf_d.shreg  = '1;
                shf_d.left   = '0;
                shf_d.line   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q.active <= 1'b0;
            shf_q.shreg  <= '1;
            shf_q.left   <= '0;
            shf_q.line   <= 1'b1;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign active = shf_q.active;
    assign line   = shf_q.line;

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
    import aftx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              cfg_len8,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              cfg_msb_first,
    input  logic              cfg_mp_mode,
    input  logic              cfg_mp_addr,
    output logic              tx_line,
    output logic              busy,
    output logic              buf_empty
);

    localparam int unsigned FRAME_W = 1 + DATA_W + AFTX_EXTRA_MAX + AFTX_STOP_MAX;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

    aftx_cfg_t          in_cfg;
    aftx_cfg_t          held_cfg;
    logic [DATA_W-1:0]  held_data;
    logic               held_full;
    logic               take;
    logic               shf_active;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   frame_len;

    always_comb begin
        in_cfg.len8      = cfg_len8;
        in_cfg.par_en    = cfg_par_en;
        in_cfg.par_odd   = cfg_par_odd;
        in_cfg.two_stop  = cfg_two_stop;
        in_cfg.msb_first = cfg_msb_first;
        in_cfg.mp_mode   = cfg_mp_mode;
        in_cfg.mp_addr   = cfg_mp_addr;
    end

    aftx_holding #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (load_data),
        .load_cfg  (in_cfg),
        .take      (take),
        .full      (held_full),
        .held_data (held_data),
        .held_cfg  (held_cfg)
    );

    aftx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
        .data      (held_data),
        .cfg       (held_cfg),
        .frame     (frame),
        .frame_len (frame_len)
    );

    aftx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .have_next  (held_full),
        .next_frame (frame),
        .next_len   (frame_len),
        .take       (take),
        .active     (shf_active),
        .line       (tx_line)
    );

    assign buf_empty = ~held_full;
    assign busy      = shf_active | held_full;

endmodule

// File: rtl/aftx_chk.sv
module aftx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic load,
    input logic tx_line,
    input logic busy,
    input logic buf_empty
);

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);

    // R4
    line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> $stable(tx_line));

    // R2
    fill_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_empty) |-> $past(load));

    // R3
    drain_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> $past(bit_tick));

    // R10
    busy_end_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(bit_tick) && tx_line));

endmodule

bind async_frame_tx aftx_chk u_chk (.*);

// File: tb/async_frame_tx_test.sv
module async_frame_tx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       load = 1'b0;
    logic [7:0] load_data = '0;
    logic [6:0] cfg = '0;   // {len8, par_en, par_odd, two_stop, msb_first, mp_mode, mp_addr}
    logic       tx_line, busy, buf_empty;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    async_frame_tx uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_tick      (bit_tick),
        .load          (load),
        .load_data     (load_data),
        .cfg_len8      (cfg[6]),
        .cfg_par_en    (cfg[5]),
        .cfg_par_odd   (cfg[4]),
        .cfg_two_stop  (cfg[3]),
        .cfg_msb_first (cfg[2]),
        .cfg_mp_mode   (cfg[1]),
        .cfg_mp_addr   (cfg[0]),
        .tx_line       (tx_line),
        .busy          (busy),
        .buf_empty     (buf_empty)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_frame(input logic [7:0] d, input logic [6:0] c, output int n);
        logic [15:0] r = '1;
        int nd = c[6] ? 8 : 7;
        logic p = c[4];
        n = 0;
        r[n] = 1'b0; n++;
        for (int i = 0; i < nd; i++) begin
            logic b = c[2] ? d[nd-1-i] : d[i];
            r[n] = b; n++;
            p = p ^ b;
        end
        if (c[1]) begin
            r[n] = c[0]; n++;
        end else if (c[5]) begin
            r[n] = p; n++;
        end
        n = n + (c[3] ? 2 : 1);
        return r;
    endfunction

    // one tick, then sample the new bit; a random gap checks the bit holds
    task automatic tick_sample(output logic v, output logic held);
        int gap;
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
        v = tx_line;
        held = 1'b1;
        gap = int'($urandom_range(0, 2));
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            if (tx_line !== v) held = 1'b0;
        end
    endtask

    task automatic put(input logic [7:0] d, input logic [6:0] c);
        @(negedge clk);
        load = 1'b1; load_data = d; cfg = c;
        @(negedge clk);
        load = 1'b0; load_data = ~d; cfg = ~c;   // later input changes must not matter
    endtask

    task automatic send_one(input logic [7:0] d, input logic [6:0] c, input string tag);
        logic [15:0] exp, got;
        int n;
        logic v, held, all_held, busy_ok;
        exp = exp_frame(d, c, n);
        got = '1;
        all_held = 1'b1;
        busy_ok = 1'b1;
        put(d, c);
        check(busy === 1'b1 && buf_empty === 1'b0, "R2 load accepted", {busy, buf_empty}, 2'b10);
        for (int k = 0; k < n; k++) begin
            tick_sample(v, held);
            got[k] = v;
            all_held &= held;
            if (busy !== 1'b1) busy_ok = 1'b0;
            if (k == 0) check(v === 1'b0 && buf_empty === 1'b1, "R3 start bit and empty", {v, buf_empty}, 2'b01);
        end
        check(got === exp, tag, got, exp);
        check(all_held, "R4 bit held between ticks", all_held, 1);
        check(busy_ok, "R10 busy during frame", busy_ok, 1);
        tick_sample(v, held);
        check(busy === 1'b0 && v === 1'b1 && buf_empty === 1'b1, "R9 R10 R1 frame end", {busy, v, buf_empty}, 3'b011);
    endtask

    initial begin
        logic [31:0] gotb, expb;
        logic [15:0] ea, eb;
        int na, nb;
        logic v, held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_line === 1'b1 && busy === 1'b0 && buf_empty === 1'b1, "R1 reset state",
              {tx_line, busy, buf_empty}, 3'b101);

        // directed corners
        send_one(8'hA5, 7'b1000000, "R5 R6 8-bit lsb first plain");
        send_one(8'hB4, 7'b1100100, "R6 R7 8-bit msb first even parity");
        send_one(8'hC3, 7'b0111000, "R5 R7 R9 7-bit odd parity two stop");
        send_one(8'h81, 7'b0000100, "R5 R6 7-bit msb first drops bit 7");
        send_one(8'h5A, 7'b1110011, "R8 mp flag 1 parity setting ignored");
        send_one(8'hFF, 7'b0101010, "R8 mp flag 0 7-bit two stop");

        // ignored load while held
        put(8'h3C, 7'b1000000);
        @(negedge clk);
        load = 1'b1; load_data = 8'hE7; cfg = 7'b0101100;
        @(negedge clk);
        load = 1'b0;
        ea = exp_frame(8'h3C, 7'b1000000, na);
        gotb = '1;
        for (int k = 0; k < na; k++) begin
            tick_sample(v, held);
            gotb[k] = v;
        end
        check(gotb[15:0] === ea, "R2 load while full ignored", gotb, {16'hffff, ea});
        tick_sample(v, held);
        check(busy === 1'b0, "R2 nothing extra queued", busy, 0);

        // back to back
        put(8'h96, 7'b1001000);
        tick_sample(v, held);
        check(v === 1'b0 && buf_empty === 1'b1, "R3 first start bit", {v, buf_empty}, 2'b01);
        put(8'h4D, 7'b0110100);
        ea = exp_frame(8'h96, 7'b1001000, na);
        eb = exp_frame(8'h4D, 7'b0110100, nb);
        gotb = '1;
        gotb[0] = v;
        for (int k = 1; k < na + nb; k++) begin
            tick_sample(v, held);
            gotb[k] = v;
        end
        expb = '1;
        for (int k = 0; k < na; k++) expb[k] = ea[k];
        for (int k = 0; k < nb; k++) expb[na + k] = eb[k];
        check(gotb === expb, "R11 back to back frames", gotb, expb);
        tick_sample(v, held);
        check(busy === 1'b0 && v === 1'b1, "R11 R10 idle after pair", {busy, v}, 2'b01);

        // random frames
        for (int r = 0; r < 40; r++) begin
            send_one(8'($urandom), 7'($urandom), "R5 R6 R7 R8 R9 random frame");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule